// File: doc/BRIEF.md
# Double-Buffered Serial Transmit Engine

This block sits between a host command interface and a frequency-shift modulator. The host writes bytes into a pair of 8-bit holding registers. Once transmission is enabled, the block sends their contents as a serial bit stream, alternating between the two registers. While one register is on the line, the host refills the other. A request flag tells the host when a register has gone out and is ready for fresh data. If the host does nothing, the block keeps circulating the old contents.

The bit period comes from the reference clock. It is set by a 7-bit rate field and a prescale bit. Both holding registers rest at the alternating pattern AAh, so enabling transmission without writing anything sends preamble.

When the buffered mode is switched off, the serial output simply follows an external data pin. The RF modulation itself is not part of this block.

Top module: `fsk_tx_serializer`

## Requirements
- R1: After reset both holding registers hold AAh. `byte_req` is 0, and in buffered mode with `tx_en` low `serial_out` is 0.
- R2: With `buf_mode` = 0, `serial_out` equals `ext_data` in the same cycle. Byte writes are ignored, so a later buffered transmission still sends AAh from both registers.
- R3: Each bit lasts exactly 29·(R+1)·M reference cycles. R is the unsigned value of `rate_sel`; M is 8 when `prescale` = 1 and 1 when `prescale` = 0.
- R4: On the rising edge of `go` (`tx_en` and `buf_mode` both 1), sending starts with register 0. The first bit lasts from that clock edge for one full period. Each byte goes out most significant bit first.
- R5: After the eighth bit of a register, the next bit comes from the other register.
- R6: While not transmitting, successive accepted writes load register 0, then register 1, then register 0 again, and so on.
- R7: While transmitting, an accepted write loads the register that is not currently being sent.
- R8: `byte_req` rises on the edge that ends the eighth bit of a register and falls on the next accepted write. It is 0 whenever the block is not transmitting.
- R9: A register that is not rewritten is sent again unchanged on its next turn.
- R10: When `go` falls, `serial_out` drops to 0 in the same cycle. At the next edge both registers return to AAh, `byte_req` clears and the idle write target returns to register 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| buf_mode | input | 1 | 1: buffered transmit, 0: direct pass-through of `ext_data` |
| tx_en | input | 1 | Transmit enable |
| rate_sel | input | 7 | Bit period multiplier R |
| prescale | input | 1 | Multiplies the bit period by 8 when 1 |
| wr_en | input | 1 | Byte write strobe, one cycle per byte |
| wr_data | input | 8 | Byte to load |
| ext_data | input | 1 | Serial data used in direct mode |
| serial_out | output | 1 | Serial bit stream |
| byte_req | output | 1 | A register has been sent and wants new data |

## Verification
Each failure mode shows up at the ports within a predictable time:
- A wrong register selector or bit index corrupts `serial_out` within one bit period of the fault. A fault on the swap after the eighth bit appears at the start of the following byte, so comparing whole multi-byte streams, including stale repeats, exposes it.
- A wrong period count shifts every following bit edge. Sampling one cycle either side of the expected edge catches an off-by-one in the first period.
- Write steering errors are seen one to two bytes later, as the wrong byte in the wrong slot.
- A failure to restore AAh on stop only appears after the next enable, as non-preamble data.

// File: rtl/fsk_txs_pkg.sv
package fsk_txs_pkg;

    localparam int BYTE_W       = 8;
    localparam int IDX_W        = $clog2(BYTE_W);
    localparam int NUM_REGS     = 2;
    localparam int DEF_RATE_W   = 7;
    localparam int DEF_BASE_DIV = 29;
    localparam int DEF_PRE_MUL  = 8;
    localparam logic [BYTE_W-1:0] IDLE_PATTERN = 8'hAA;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic {
        TXS_IDLE = 1'b0,
        TXS_SEND = 1'b1
    } txs_state_e;

    typedef struct packed {
        logic             sel;
        logic [IDX_W-1:0] idx;
    } txs_pos_t;

    // Reference cycles in one bit for a given rate field and prescale bit
    function automatic int bit_period(int rate, logic pre, int base, int mul);
        return base * (rate + 1) * (pre ? mul : 1);
    endfunction

endpackage

// File: rtl/fsk_txs_bitclk.sv
module fsk_txs_bitclk
    import fsk_txs_pkg::*;
#(
    parameter int RATE_W   = DEF_RATE_W,
    parameter int BASE_DIV = DEF_BASE_DIV,
    parameter int PRE_MUL  = DEF_PRE_MUL
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              run,
    input  logic [RATE_W-1:0] rate,
    input  logic              pre,
    output logic              tick
);
    localparam int MAX_PER = BASE_DIV * (2 ** RATE_W) * PRE_MUL;
    localparam int CNT_W   = $clog2(MAX_PER);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] reload;

    always_comb begin
        reload = CNT_W'(bit_period(int'(rate), pre, BASE_DIV, PRE_MUL) - 1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= reload;
        end else if (run) begin
            if (cnt_q == '0) begin
                cnt_q <= reload;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign tick = run && (cnt_q == '0);

endmodule

// File: rtl/fsk_txs_seq.sv
module fsk_txs_seq
    import fsk_txs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic             tick,
    input  logic             wr_hit,
    output logic             start,
    output logic             stop,
    output logic             active,
    output logic             cur_sel,
    output logic [IDX_W-1:0] bit_idx,
    output logic             req
);
    txs_state_e state_q;
    txs_pos_t   pos_q;
    logic       req_q;
    logic       last_bit;

    assign start    = (state_q == TXS_IDLE) && go;
    assign stop     = (state_q == TXS_SEND) && !go;
    assign last_bit = tick && (pos_q.idx == IDX_W'(BYTE_W - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= TXS_IDLE;
            pos_q   <= '0;
            req_q   <= 1'b0;
        end else if (start || stop) begin
            state_q <= start ? TXS_SEND : TXS_IDLE;
            pos_q   <= '0;
            req_q   <= 1'b0;
        end else if (state_q == TXS_SEND) begin
            if (last_bit) begin
                pos_q.idx <= '0;
                pos_q.sel <= ~pos_q.sel;
                req_q     <= 1'b1;
            end else begin
                if (tick) begin
                    pos_q.idx <= pos_q.idx + 1'b1;
                end
                if (wr_hit) begin
                    req_q <= 1'b0;
                end
            end
        end
    end

    assign active  = (state_q == TXS_SEND);
    assign cur_sel = pos_q.sel;
    assign bit_idx = pos_q.idx;
    assign req     = req_q;

endmodule

// File: rtl/fsk_txs_dbuf.sv
module fsk_txs_dbuf
    import fsk_txs_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clear,
    input  logic                 wr_en,
    input  logic                 wr_sel,
    input  byte_t                wr_data,
    input  logic                 rd_sel,
    input  logic [IDX_W-1:0]     rd_idx,
    output logic                 bit_out,
    output byte_t [NUM_REGS-1:0] regs_o
);
    logic [IDX_W-1:0] msb_idx;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_hold
        byte_t hold_q;

        always_ff @(posedge clk) begin
            if (rst || clear) begin
                hold_q <= IDLE_PATTERN;
            end else if (wr_en && (wr_sel == 1'(g))) begin
                hold_q <= wr_data;
            end
        end

        assign regs_o[g] = hold_q;
    end

    assign msb_idx = IDX_W'(BYTE_W - 1) - rd_idx;
    assign bit_out = regs_o[rd_sel][msb_idx];

endmodule

// File: rtl/fsk_tx_serializer.sv
module fsk_tx_serializer
    import fsk_txs_pkg::*;
#(
    parameter int RATE_W   = DEF_RATE_W,
    parameter int BASE_DIV = DEF_BASE_DIV,
    parameter int PRE_MUL  = DEF_PRE_MUL
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              buf_mode,
    input  logic              tx_en,
    input  logic [RATE_W-1:0] rate_sel,
    input  logic              prescale,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    input  logic              ext_data,
    output logic              serial_out,
    output logic              byte_req
);
    logic                 go;
    logic                 start;
    logic                 stop;
    logic                 active;
    logic                 tick;
    logic                 cur_sel;
    logic [IDX_W-1:0]     bit_idx;
    logic                 wr_ok;
    logic                 wr_sel;
    logic                 fill_ptr_q;
    logic                 shift_bit;
    byte_t [NUM_REGS-1:0] regs_q;

    assign go     = tx_en && buf_mode;
    assign wr_ok  = wr_en && buf_mode;
    assign wr_sel = active ? ~cur_sel : fill_ptr_q;

    // Idle write target alternates and returns to register 0 on stop
    always_ff @(posedge clk) begin
        if (rst || stop) begin
            fill_ptr_q <= 1'b0;
        end else if (!active && wr_ok) begin
            fill_ptr_q <= ~fill_ptr_q;
        end
    end

    fsk_txs_bitclk #(
        .RATE_W  (RATE_W),
        .BASE_DIV(BASE_DIV),
        .PRE_MUL (PRE_MUL)
    ) u_bitclk (
        .clk (clk),
        .rst (rst),
        .load(start),
        .run (active),
        .rate(rate_sel),
        .pre (prescale),
        .tick(tick)
    );

    fsk_txs_seq u_seq (
        .clk    (clk),
        .rst    (rst),
        .go     (go),
        .tick   (tick),
        .wr_hit (wr_ok),
        .start  (start),
        .stop   (stop),
        .active (active),
        .cur_sel(cur_sel),
        .bit_idx(bit_idx),
        .req    (byte_req)
    );

    fsk_txs_dbuf u_dbuf (
        .clk    (clk),
        .rst    (rst),
        .clear  (stop),
        .wr_en  (wr_ok && !stop),
        .wr_sel (wr_sel),
        .wr_data(wr_data),
        .rd_sel (cur_sel),
        .rd_idx (bit_idx),
        .bit_out(shift_bit),
        .regs_o (regs_q)
    );

    assign serial_out = buf_mode ? (go && active && shift_bit) : ext_data;

endmodule

// File: rtl/fsk_txs_chk.sv
module fsk_txs_chk
    import fsk_txs_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             go,
    input logic             tick,
    input logic             active,
    input logic             stop,
    input logic             cur_sel,
    input logic [IDX_W-1:0] bit_idx,
    input logic             byte_req,
    input byte_t            reg0,
    input byte_t            reg1
);
    AST_FIRST_REG: assert property (@(posedge clk) disable iff (rst)
        $rose(active) |-> (!cur_sel && bit_idx == '0)); // R4

    AST_SWAP_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        (active && go && tick && bit_idx == IDX_W'(BYTE_W - 1))
            |=> (cur_sel != $past(cur_sel))); // R5

    AST_REQ_ON_DONE: assert property (@(posedge clk) disable iff (rst)
        (active && go && tick && bit_idx == IDX_W'(BYTE_W - 1)) |=> byte_req); // R8

    AST_REQ_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        !active |-> !byte_req); // R8

    AST_PRESET_ON_STOP: assert property (@(posedge clk) disable iff (rst)
        stop |=> (reg0 == IDLE_PATTERN && reg1 == IDLE_PATTERN)); // R10

    AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (rst)
        (active && go && !tick) |=> ($stable(bit_idx) && $stable(cur_sel))); // R3

endmodule

bind fsk_tx_serializer fsk_txs_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .go      (go),
    .tick    (tick),
    .active  (active),
    .stop    (stop),
    .cur_sel (cur_sel),
    .bit_idx (bit_idx),
    .byte_req(byte_req),
    .reg0    (regs_q[0]),
    .reg1    (regs_q[1])
);

// File: tb/fsk_tx_serializer_tb.sv
module fsk_tx_serializer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG_LIMIT = 180000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       buf_mode = 1'b1;
    logic       tx_en = 1'b0;
    logic [6:0] rate_sel = '0;
    logic       prescale = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       ext_data = 1'b0;
    logic       serial_out;
    logic       byte_req;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int per = 29;
    bit first_bit = 1'b1;
    logic req_first;
    logic req_last;

    fsk_tx_serializer u_dut (
        .clk       (clk),
        .rst       (rst),
        .buf_mode  (buf_mode),
        .tx_en     (tx_en),
        .rate_sel  (rate_sel),
        .prescale  (prescale),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .ext_data  (ext_data),
        .serial_out(serial_out),
        .byte_req  (byte_req)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > WDOG_LIMIT) begin
            checks++;
            errors++;
            $display("FAIL R3 watchdog expired actual=%0d expected<=%0d", cycles, WDOG_LIMIT);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    function automatic int period_of(int r, logic cs);
        return 29 * (r + 1) * (cs ? 8 : 1);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic idle_write(logic [7:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        step();
    endtask

    // Raise enable at a falling edge; returns just after the start edge
    task automatic begin_tx(int r, logic cs);
        @(negedge clk);
        rate_sel  = 7'(r);
        prescale  = cs;
        tx_en     = 1'b1;
        per       = period_of(r, cs);
        first_bit = 1'b1;
        step();
    endtask

    task automatic end_tx();
        @(negedge clk);
        tx_en = 1'b0;
        #1 chk("R10 output low at once", 32'(serial_out), 32'd0);
        step();
        @(negedge clk);
        chk("R10 request cleared on stop", 32'(byte_req), 32'd0);
    endtask

    // Sample eight bits mid-period; optionally write a byte after bit wr_at
    task automatic check_byte(logic [7:0] b, string tag, int wr_at, logic [7:0] wv);
        for (int k = 0; k < 8; k++) begin
            int n;
            n = first_bit ? per / 2 : per;
            first_bit = 1'b0;
            for (int i = 0; i < n; i++) step();
            @(negedge clk);
            chk(tag, 32'(serial_out), 32'(b[7-k]));
            if (k == 0) req_first = byte_req;
            if (k == 7) req_last = byte_req;
            if (k == wr_at) begin
                wr_en   = 1'b1;
                wr_data = wv;
            end
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 idle output", 32'(serial_out), 32'd0);
        chk("R1 request after reset", 32'(byte_req), 32'd0);

        // Direct mode pass-through and ignored writes
        buf_mode = 1'b0;
        ext_data = 1'b1;
        #1 chk("R2 follows ext high", 32'(serial_out), 32'd1);
        ext_data = 1'b0;
        tx_en    = 1'b1;
        #1 chk("R2 follows ext low with enable", 32'(serial_out), 32'd0);
        ext_data = 1'b1;
        #1 chk("R2 follows ext high with enable", 32'(serial_out), 32'd1);
        idle_write(8'h00);
        idle_write(8'h0F);
        @(negedge clk);
        tx_en    = 1'b0;
        ext_data = 1'b0;
        buf_mode = 1'b1;
        begin_tx(0, 1'b0);
        check_byte(8'hAA, "R2 direct writes ignored reg0", -1, 8'h00);
        check_byte(8'hAA, "R1 preset reg1", -1, 8'h00);
        end_tx();

        // Steering, request flag, stale repeat
        idle_write(8'h3C);
        idle_write(8'hC5);
        begin_tx(1, 1'b0);
        check_byte(8'h3C, "R4 first byte from reg0 msb first", 3, 8'h93);
        chk("R8 no request during first byte", 32'(req_last), 32'd0);
        check_byte(8'h93, "R7 active write lands in idle register", 4, 8'h5A);
        chk("R8 request after first byte", 32'(req_first), 32'd1);
        chk("R8 request cleared by write", 32'(req_last), 32'd0);
        check_byte(8'h5A, "R5 swap back to reg0", -1, 8'h00);
        chk("R8 request after second byte", 32'(req_first), 32'd1);
        check_byte(8'h93, "R9 stale register repeated", -1, 8'h00);
        chk("R9 request still raised", 32'(req_last), 32'd1);
        end_tx();

        // Registers return to preset after stop
        begin_tx(0, 1'b0);
        check_byte(8'hAA, "R10 reg0 preset after stop", -1, 8'h00);
        check_byte(8'hAA, "R10 reg1 preset after stop", -1, 8'h00);
        end_tx();

        // Idle write target returns to register 0 after stop
        idle_write(8'h11);
        begin_tx(0, 1'b0);
        check_byte(8'h11, "R6 first idle write to reg0", -1, 8'h00);
        end_tx();
        idle_write(8'hE7);
        begin_tx(0, 1'b0);
        check_byte(8'hE7, "R10 write target back to reg0", -1, 8'h00);
        check_byte(8'hAA, "R10 reg1 untouched", -1, 8'h00);
        end_tx();

        // Exact bit edge with prescale and with a larger rate field
        for (int m = 0; m < 2; m++) begin
            logic cs;
            int   r;
            cs = (m == 0);
            r  = (m == 0) ? 0 : 2;
            begin_tx(r, cs);
            for (int i = 0; i < per - 1; i++) step();
            @(negedge clk);
            chk("R3 first bit still on line before period end", 32'(serial_out), 32'd1);
            step();
            @(negedge clk);
            chk("R3 second bit exactly one period later", 32'(serial_out), 32'd0);
            end_tx();
        end

        // Random bytes and rates
        for (int t = 0; t < 16; t++) begin
            logic [7:0] b0;
            logic [7:0] b1;
            int         r;
            b0 = 8'($urandom);
            b1 = 8'($urandom);
            r  = int'($urandom % 4);
            idle_write(b0);
            idle_write(b1);
            begin_tx(r, 1'b0);
            check_byte(b0, "R6 random reg0", -1, 8'h00);
            check_byte(b1, "R5 random reg1", -1, 8'h00);
            check_byte(b0, "R9 random stale repeat", -1, 8'h00);
            end_tx();
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule